// File: doc/BRIEF.md
# HDLC Transmit Framer with Underrun Close

The block turns a stream of host bytes into a serial HDLC frame, one bit for each bit-enable strobe. While no frame is in progress it sends back-to-back flag octets (01111110). The host offers a byte with a valid signal. The framer takes it only at the strobe that sends the last bit of the current octet. That is either the last bit of a flag, which starts a new frame, or the last bit of a data byte, which continues the frame.

No end-of-frame command exists. If no byte is valid at that decision strobe, the host has run late, and the frame ends there. The framer then sends the 16-bit frame check sequence, then a closing flag, and then goes back to idle flags. A status output is high from the decision strobe until the first bit of the closing flag goes out. Data and check bits are sent least significant bit first. A zero is inserted after every run of five ones, but never inside a flag.

A new frame may start on the last bit of the closing flag, so two frames can share one flag. Bit timing, modulation and host bus decoding are handled outside the block.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `tx_bit` is 1 and `tx_end` is 0. When no frame is in progress, each strobe sends the next bit of the flag 0x7E, LSB first (0,1,1,1,1,1,1,0), starting at bit 0 after reset.
- R2: `in_ready` is 1 only on a strobe cycle that sends bit 7 of a flag or a data byte and is not a stuffing slot. A byte is taken when `in_ready` and `in_valid` are both 1 in the same cycle.
- R3: A taken byte is sent LSB first on the eight strobes that follow, not counting stuffing slots.
- R4: After five consecutive 1s in data or check bits, the next strobe sends a 0 that carries no payload. This includes a run that ends on the last check bit. Flags never get stuffing.
- R5: The check sequence is the inverse of a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over the data bits. It is sent as 16 bits, LSB first, so the low byte goes out first.
- R6: If `in_valid` is 0 at the decision strobe of a data byte, the first check bit is sent on the next payload strobe.
- R7: `tx_end` rises on the same clock that shows the last data bit of the frame.
- R8: `tx_end` falls on the same clock that shows the first bit of the closing flag. A stuffing zero after the last check bit leaves it high.
- R9: A byte that is valid on bit 7 of the closing flag is taken and starts the next frame, so the two frames share that flag.
- R10: On cycles without a strobe, `tx_bit` and `tx_end` hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit time |
| in_data | input | 8 | Host byte offered |
| in_valid | input | 1 | Host byte is present |
| in_ready | output | 1 | Byte taken this cycle if valid |
| tx_bit | output | 1 | Registered serial output bit |
| tx_end | output | 1 | Frame is closing (check bits in flight) |

## Verification
The decision strobe does two jobs at once: it may take a host byte, or it may close the frame and load the check value. Both outcomes are provoked with the same pattern. A byte is pushed during the check phase so that it is valid exactly on the last bit of the closing flag, and frames of 0xFF bytes make a stuffing slot land on or next to the decision point, which shifts that point by one strobe. A reference model in the bench predicts `in_ready`, `tx_bit` and `tx_end` on every clock, both with a strobe every cycle and with sparse strobes.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int CNT_W  = $clog2(CRC_W);
    localparam int ONES_W = 3;

    typedef enum logic [1:0] {PH_FLAG, PH_DATA, PH_FCS} phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [ONES_W-1:0]   ones;
        logic [BYTE_W-1:0]   shreg;
        logic [CRC_W-1:0]    crc;
        logic                bit_o;
        logic                endf;
    } fr_state_t;
endpackage

// File: rtl/hdlc_tx_crc_step.sv
module hdlc_tx_crc_step #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8408
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = crc_i[0] ^ bit_i;
        crc_o = {1'b0, crc_i[W-1:1]} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/hdlc_tx_stuff_chk.sv
module hdlc_tx_stuff_chk #(
    parameter int RUN = 5,
    parameter int OW  = 3
) (
    input  logic          strobe_i,
    input  logic [OW-1:0] ones_i,
    output logic          stuff_o
);
    localparam logic [OW-1:0] RUN_V = OW'(RUN);
    always_comb stuff_o = strobe_i && (ones_i == RUN_V);
endmodule

// File: rtl/hdlc_tx_flag_bit.sv
module hdlc_tx_flag_bit #(
    parameter logic [7:0] PAT = 8'h7E
) (
    input  logic [2:0] idx_i,
    output logic       bit_o
);
    always_comb bit_o = PAT[idx_i];
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter logic [7:0]       FLAG_PAT  = 8'h7E,
    parameter int               STUFF_RUN = 5,
    parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              tx_end
);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(CRC_W - 1);
    localparam fr_state_t RESET_ST = '{ph: PH_FLAG, cnt: '0, ones: '0,
                                       shreg: '0, crc: '0, bit_o: 1'b1, endf: 1'b0};

    fr_state_t state_q, state_d;
    logic stuff_now, flag_bit, cur_bit, load_pt, take;
    logic [CRC_W-1:0] crc_nx;

    hdlc_tx_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i(state_q.crc), .bit_i(state_q.shreg[0]), .crc_o(crc_nx));

    hdlc_tx_stuff_chk #(.RUN(STUFF_RUN), .OW(ONES_W)) u_stuff (
        .strobe_i(bit_en), .ones_i(state_q.ones), .stuff_o(stuff_now));

    hdlc_tx_flag_bit #(.PAT(FLAG_PAT)) u_flag (
        .idx_i(state_q.cnt[2:0]), .bit_o(flag_bit));

    always_comb begin
        state_d = state_q;
        unique case (state_q.ph)
            PH_FLAG: cur_bit = flag_bit;
            PH_DATA: cur_bit = state_q.shreg[0];
            default: cur_bit = state_q.crc[0];
        endcase
        load_pt = bit_en && !stuff_now && (state_q.ph != PH_FCS)
                  && (state_q.cnt == BYTE_LAST);
        take    = load_pt && in_valid;

        if (bit_en) begin
            if (stuff_now) begin
                state_d.bit_o = 1'b0;
                state_d.ones  = '0;
            end else begin
                state_d.bit_o = cur_bit;
                if (state_q.ph == PH_FLAG || !cur_bit) state_d.ones = '0;
                else                                   state_d.ones = state_q.ones + 1'b1;
                unique case (state_q.ph)
                    PH_FLAG: begin
                        if (state_q.cnt == '0) state_d.endf = 1'b0;
                        if (state_q.cnt == BYTE_LAST) begin
                            state_d.cnt = '0;
                            if (take) begin
                                state_d.ph    = PH_DATA;
                                state_d.shreg = in_data;
                                state_d.crc   = CRC_INIT;
                            end
                        end else begin
                            state_d.cnt = state_q.cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        state_d.crc   = crc_nx;
                        state_d.shreg = {1'b0, state_q.shreg[BYTE_W-1:1]};
                        if (state_q.cnt == BYTE_LAST) begin
                            state_d.cnt = '0;
                            if (take) begin
                                state_d.shreg = in_data;
                            end else begin
                                state_d.ph   = PH_FCS;
                                state_d.crc  = ~crc_nx;
                                state_d.endf = 1'b1;
                            end
                        end else begin
                            state_d.cnt = state_q.cnt + 1'b1;
                        end
                    end
                    default: begin
                        state_d.crc = {1'b1, state_q.crc[CRC_W-1:1]};
                        if (state_q.cnt == FCS_LAST) begin
                            state_d.cnt = '0;
                            state_d.ph  = PH_FLAG;
                        end else begin
                            state_d.cnt = state_q.cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    assign in_ready = load_pt;
    assign tx_bit   = state_q.bit_o;
    assign tx_end   = state_q.endf;

    p_ready_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(tx_end)));

    p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_now |=> !tx_bit);

    p_flag_no_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ph == PH_FLAG && state_q.cnt != '0) |-> (state_q.ones == '0));

    p_end_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> ($past(state_q.ph) == PH_DATA));

    p_end_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> (state_q.ph == PH_FCS ||
                    (state_q.ph == PH_FLAG && state_q.cnt == '0)));
endmodule

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, bit_en, in_valid, in_ready, tx_bit, tx_end;
    logic [7:0] in_data;

    hdlc_tx_framer u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
                       .in_valid(in_valid), .in_ready(in_ready), .tx_bit(tx_bit),
                       .tx_end(tx_end));

    int total = 0, bad = 0, cycles = 0, tick = 0, per = 1;
    logic [7:0] hostq[$];
    int m_mode = 0, m_pos = 0, m_run = 0, m_crc = 0, m_sh = 0, m_kind = 0;
    bit m_bit = 1'b1, m_end = 1'b0, m_after = 1'b0, prev_strobe = 1'b0;

    task automatic chk(input bit got, input bit exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: got=%0b exp=%0b", tag, cycles, got, exp);
        end
    endtask

    function automatic int crc_bit(input int c, input int b);
        int f = (c ^ b) & 1;
        return (c >> 1) ^ (f ? 'h8408 : 0);
    endfunction

    task automatic model_step(input bit tk, input logic [7:0] d);
        int b;
        if (m_run == 5) begin
            m_bit = 1'b0; m_run = 0; m_kind = 3;
            return;
        end
        if (m_mode == 0) begin
            b = (8'h7E >> m_pos) & 1; m_kind = 0; m_run = 0;
            if (m_pos == 0) m_end = 1'b0;
            if (m_pos == 7) begin
                m_pos = 0; m_after = 1'b0;
                if (tk) begin m_mode = 1; m_sh = d; m_crc = 'hFFFF; end
            end else m_pos++;
        end else if (m_mode == 1) begin
            b = m_sh & 1; m_kind = 1;
            m_crc = crc_bit(m_crc, b); m_sh = m_sh >> 1;
            m_run = b ? m_run + 1 : 0;
            if (m_pos == 7) begin
                m_pos = 0;
                if (tk) m_sh = d;
                else begin m_mode = 2; m_crc = (~m_crc) & 'hFFFF; m_end = 1'b1; m_kind = 4; end
            end else m_pos++;
        end else begin
            b = m_crc & 1; m_kind = 2; m_crc = m_crc >> 1;
            m_run = b ? m_run + 1 : 0;
            if (m_pos == 15) begin m_pos = 0; m_mode = 0; m_after = 1'b1; end
            else m_pos++;
        end
        m_bit = b[0];
    endtask

    task automatic cyc();
        string tb_tag, te_tag;
        bit rdy, tk;
        logic [7:0] d;
        @(negedge clk);
        if (!prev_strobe) begin tb_tag = "R10"; te_tag = "R10"; end
        else begin
            case (m_kind)
                0: tb_tag = "R1";
                1: tb_tag = "R3";
                2: tb_tag = "R5";
                3: tb_tag = "R4";
                default: tb_tag = "R6";
            endcase
            te_tag = m_end ? "R7" : "R8";
        end
        chk(tx_bit, m_bit, tb_tag);
        chk(tx_end, m_end, te_tag);
        bit_en   = ((tick % per) == 0);
        tick++;
        in_valid = (hostq.size() > 0);
        d        = in_valid ? hostq[0] : 8'h00;
        in_data  = d;
        #1;
        rdy = bit_en && (m_run != 5) && (m_mode != 2) && (m_pos == 7);
        chk(in_ready, rdy, bit_en ? (m_after ? "R9" : "R2") : "R10");
        prev_strobe = bit_en;
        tk = rdy && in_valid;
        if (bit_en) model_step(tk, d);
        if (tk) void'(hostq.pop_front());
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL R1 watchdog expired: got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_frame();
        while (hostq.size() > 0) cyc();
        while (m_mode != 2) cyc();
        while (m_mode != 0 || m_end) cyc();
        run_n(12 * per);
    endtask

    initial begin
        int c;
        bit_en = 1'b0; in_valid = 1'b0; in_data = 8'h00; rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(tx_bit, 1'b1, "R1");
        chk(tx_end, 1'b0, "R1");
        // R5: known-answer check of the bench CRC (inverted result 0x906E)
        c = 'hFFFF;
        for (int k = 0; k < 9; k++)
            for (int j = 0; j < 8; j++) c = crc_bit(c, ((8'h31 + k) >> j) & 1);
        total++;
        if (((~c) & 'hFFFF) != 'h906E) begin
            bad++; $display("FAIL R5 crc self-test: got=%h exp=906e", (~c) & 'hFFFF);
        end

        per = 1; run_n(40);
        hostq.push_back(8'h55); finish_frame();
        hostq.push_back(8'hFF); hostq.push_back(8'hFF); hostq.push_back(8'hFF);
        hostq.push_back(8'h7E); finish_frame();
        per = 3;
        hostq.push_back(8'h12); hostq.push_back(8'h34); hostq.push_back(8'hA5);
        finish_frame();
        per = 1;
        // R9: next frame offered while the first is closing
        hostq.push_back(8'h0F); hostq.push_back(8'hF0);
        while (!m_end) cyc();
        hostq.push_back(8'h3C);
        finish_frame();
        per = 2;
        for (int k = 0; k < 6; k++) hostq.push_back(8'($urandom_range(0, 255)));
        finish_frame();
        per = 1;
        hostq.push_back(8'hFF); hostq.push_back(8'h1F); finish_frame();
        run_n(20);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule